// File: doc/BRIEF.md
# Write-Protect Unlock Sequencer

This block sits between the page-load front end of a byte-wide nonvolatile memory and that memory's programming controller. It watches every bus write command, each one an address and a data byte, and decides what happens to it. Out of reset the memory is protected. Writing is allowed only after a fixed three-command key has been seen, and then only for a single programming operation. Protection returns by itself when that programming cycle reports completion.

Each accepted key command raises a flag that tells the front end not to store that byte. The key addresses otherwise remain ordinary storage locations. After the key, the next write opens the write window. The window stays open for the rest of that page load. A write made without the full key stores nothing. Instead it raises a one-cycle request that starts a dummy programming timer, so the memory looks busy for a full write cycle and reads act as status polls.

All three outputs are registered. Each one reflects the write strobe, timeout or done pulse of the previous clock cycle.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset, writeEnabled, suppressStore and spuriousReq are all 0, and the sequencer is protected.
- R2: The key is three strobed writes in this order: data 0xAA at address 0x5555, then data 0x55 at address 0x2AAA, then data 0xA0 at address 0x5555. For each accepted key write, suppressStore is 1 in the cycle after the strobe and 0 otherwise. writeEnabled stays 0 while the key is being entered.
- R3: The first write after a complete key drives writeEnabled to 1 from the cycle after its strobe. suppressStore is 0 for that write. writeEnabled stays 1 through further writes of the same page load.
- R4: A progDone pulse while writeEnabled is 1 clears writeEnabled in the next cycle. A write after that, made without a new key, is treated as a spurious write.
- R5: A write while protected that is not key step one produces a one-cycle spuriousReq pulse in the cycle after its strobe. It produces neither suppressStore nor writeEnabled.
- R6: A write during a partial key that does not match the expected step discards the partial key and is treated as spurious. The exception is a write of 0xAA at 0x5555: it is accepted as key step one, with suppressStore and no spuriousReq.
- R7: A loadTimeout pulse with no write strobe in the same cycle discards a partial or complete key that is still waiting for data. When a strobe and loadTimeout arrive in the same cycle, the strobe is processed and the timeout is ignored.
- R8: After a spurious write and until the next progDone, writes raise no output (no spuriousReq, suppressStore or writeEnabled). progDone then returns the sequencer to protected idle.
- R9: loadTimeout has no effect while writeEnabled is 1. progDone has no effect while protected or during a partial key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrStb | input | 1 | One-cycle strobe for one bus write command |
| wrAddr | input | 15 | Address of the write command |
| wrData | input | 8 | Data byte of the write command |
| loadTimeout | input | 1 | Byte-load window expired pulse |
| progDone | input | 1 | Programming cycle (real or dummy) finished pulse |
| writeEnabled | output | 1 | Writes of this operation may be stored |
| suppressStore | output | 1 | The previous write was a key command and must not be stored |
| spuriousReq | output | 1 | Start a dummy programming timer |

## Verification
Directed sequences cover the clean key followed by a page load and relock. They also cover a wrong byte at each key step, a wrong byte that is itself step one, and a timeout at every key stage. A timeout that coincides with a strobe is included, as are writes during the dummy busy period. These cases separate the idle, partial-key, armed, open and dummy-busy states. Random stimulus is then drawn mostly from the key commands and near-miss commands, with sparse timeout and done pulses. This exercises the restart and relock paths in orders the directed cases do not reach. Every cycle is compared with a bench-side reference model.

// File: rtl/wp_unlock_pkg.sv
package wp_unlock_pkg;

  typedef enum logic [2:0] {
    ST_LOCKED = 3'd0,
    ST_GOT1   = 3'd1,
    ST_GOT2   = 3'd2,
    ST_ARMED  = 3'd3,
    ST_OPEN   = 3'd4,
    ST_DUMMY  = 3'd5
  } seqState_t;

  typedef struct packed {
    logic markKey;
    logic fireSpurious;
    logic openWin;
    logic closeWin;
  } seqStrobe_t;

endpackage

// File: rtl/wp_unlock_datapath.sv
module wp_unlock_datapath
  import wp_unlock_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int KEY_STEPS = 3,
  parameter logic [KEY_STEPS*ADDR_W-1:0] KEY_ADDRS = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [KEY_STEPS*DATA_W-1:0] KEY_DATAS = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  seqStrobe_t           strobe,
  output logic [KEY_STEPS-1:0] keyHit,
  output logic                 suppressStore,
  output logic                 spuriousReq,
  output logic                 writeEnabled
);

  for (genvar k = 0; k < KEY_STEPS; k++) begin : g_keyCmp
    assign keyHit[k] = (wrAddr == KEY_ADDRS[k*ADDR_W +: ADDR_W]) &&
                       (wrData == KEY_DATAS[k*DATA_W +: DATA_W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suppressStore <= 1'b0;
      spuriousReq   <= 1'b0;
      writeEnabled  <= 1'b0;
    end else begin
      suppressStore <= strobe.markKey;
      spuriousReq   <= strobe.fireSpurious;
      if (strobe.closeWin)     writeEnabled <= 1'b0;
      else if (strobe.openWin) writeEnabled <= 1'b1;
    end
  end

  AST_KEY_NOT_STORED_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    suppressStore |-> !writeEnabled); // R2
  AST_SPUR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    spuriousReq |=> !spuriousReq); // R8
  AST_SPUR_NOT_KEY: assert property (@(posedge clk) disable iff (!rstN)
    !(spuriousReq && suppressStore)); // R5

endmodule

// File: rtl/wp_unlock_control.sv
module wp_unlock_control
  import wp_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic       loadTimeout,
  input  logic       progDone,
  input  logic [2:0] keyHit,
  output seqStrobe_t strobe
);

  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_LOCKED, ST_GOT1, ST_GOT2: begin
        if (wrStb) begin
          if (state == ST_GOT1 && keyHit[1]) begin
            stateNxt       = ST_GOT2;
            strobe.markKey = 1'b1;
          end else if (state == ST_GOT2 && keyHit[2]) begin
            stateNxt       = ST_ARMED;
            strobe.markKey = 1'b1;
          end else if (keyHit[0]) begin
            stateNxt       = ST_GOT1;
            strobe.markKey = 1'b1;
          end else begin
            stateNxt            = ST_DUMMY;
            strobe.fireSpurious = 1'b1;
          end
        end else if (loadTimeout) begin
          stateNxt = ST_LOCKED;
        end
      end
      ST_ARMED: begin
        if (wrStb) begin
          stateNxt       = ST_OPEN;
          strobe.openWin = 1'b1;
        end else if (loadTimeout) begin
          stateNxt = ST_LOCKED;
        end
      end
      ST_OPEN: begin
        if (progDone) begin
          stateNxt        = ST_LOCKED;
          strobe.closeWin = 1'b1;
        end
      end
      ST_DUMMY: begin
        if (progDone) stateNxt = ST_LOCKED;
      end
      default: stateNxt = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= stateNxt;
  end

  AST_OPEN_ONLY_AFTER_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN) |-> ($past(state) == ST_ARMED || $past(state) == ST_OPEN)); // R3
  AST_DONE_RELOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN && progDone) |=> (state == ST_LOCKED)); // R4
  AST_TIMEOUT_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN && !progDone) |=> (state == ST_OPEN)); // R9
  AST_DUMMY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DUMMY && !progDone) |=> (state == ST_DUMMY)); // R8

endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
  import wp_unlock_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              loadTimeout,
  input  logic              progDone,
  output logic              writeEnabled,
  output logic              suppressStore,
  output logic              spuriousReq
);

  localparam int KEY_STEPS = 3;
  localparam logic [KEY_STEPS*ADDR_W-1:0] KEY_ADDRS =
    {ADDR_W'(15'h5555), ADDR_W'(15'h2AAA), ADDR_W'(15'h5555)};
  localparam logic [KEY_STEPS*DATA_W-1:0] KEY_DATAS =
    {DATA_W'(8'hA0), DATA_W'(8'h55), DATA_W'(8'hAA)};

  seqStrobe_t           strobe;
  logic [KEY_STEPS-1:0] keyHit;

  wp_unlock_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrStb       (wrStb),
    .loadTimeout (loadTimeout),
    .progDone    (progDone),
    .keyHit      (keyHit),
    .strobe      (strobe)
  );

  wp_unlock_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KEY_STEPS (KEY_STEPS),
    .KEY_ADDRS (KEY_ADDRS),
    .KEY_DATAS (KEY_DATAS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .strobe        (strobe),
    .keyHit        (keyHit),
    .suppressStore (suppressStore),
    .spuriousReq   (spuriousReq),
    .writeEnabled  (writeEnabled)
  );

endmodule

// File: tb/tb_wp_unlock_seq.sv
module tb_wp_unlock_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        loadTimeout = 1'b0;
  logic        progDone = 1'b0;
  logic        writeEnabled, suppressStore, spuriousReq;

  int checks = 0;
  int errors = 0;
  int mState = 0;        // 0 idle,1 got1,2 got2,3 armed,4 open,5 dummy
  logic eEn = 0, eSup = 0, eSpur = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wp_unlock_seq dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .loadTimeout(loadTimeout), .progDone(progDone),
    .writeEnabled(writeEnabled), .suppressStore(suppressStore), .spuriousReq(spuriousReq)
  );

  function automatic bit isKey(int step, logic [14:0] a, logic [7:0] d);
    case (step)
      0: return a == 15'h5555 && d == 8'hAA;
      1: return a == 15'h2AAA && d == 8'h55;
      default: return a == 15'h5555 && d == 8'hA0;
    endcase
  endfunction

  // Reference model of the requirements, advanced once per cycle.
  task automatic modelStep(bit s, logic [14:0] a, logic [7:0] d, bit to, bit pd);
    eSup = 0; eSpur = 0;
    if (mState <= 2) begin
      if (s) begin
        if (mState > 0 && isKey(mState, a, d)) begin mState = mState + 1; eSup = 1; end
        else if (isKey(0, a, d)) begin mState = 1; eSup = 1; end
        else begin mState = 5; eSpur = 1; end
      end else if (to) mState = 0;
    end else if (mState == 3) begin
      if (s) mState = 4;
      else if (to) mState = 0;
    end else if (mState == 4) begin
      if (pd) mState = 0;
    end else begin
      if (pd) mState = 0;
    end
    eEn = (mState == 4);
  endtask

  task automatic check(string tag);
    checks++;
    if (writeEnabled !== eEn || suppressStore !== eSup || spuriousReq !== eSpur) begin
      errors++;
      $display("FAIL %s: en/sup/spur actual %b%b%b expected %b%b%b", tag,
               writeEnabled, suppressStore, spuriousReq, eEn, eSup, eSpur);
    end
  endtask

  task automatic cyc(bit s, logic [14:0] a, logic [7:0] d, bit to, bit pd, string tag);
    wrStb = s; wrAddr = a; wrData = d; loadTimeout = to; progDone = pd;
    @(posedge clk);
    modelStep(s, a, d, to, pd);
    @(negedge clk);
    wrStb = 0; loadTimeout = 0; progDone = 0;
    check(tag);
  endtask

  task automatic key3(string tag);
    cyc(1, 15'h5555, 8'hAA, 0, 0, tag);
    cyc(1, 15'h2AAA, 8'h55, 0, 0, tag);
    cyc(1, 15'h5555, 8'hA0, 0, 0, tag);
  endtask

  function automatic string tagOf();
    if (eSpur) return "R5";
    if (eSup)  return "R2";
    if (eEn)   return "R3";
    return "R9";
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234ABCD;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1;
    @(negedge clk);
    check("R1");

    // Clean key, page load, relock
    key3("R2");
    cyc(1, 15'h0100, 8'h3C, 0, 0, "R3");
    cyc(1, 15'h0101, 8'h3D, 0, 0, "R3");
    cyc(0, 15'h0, 8'h0, 1, 0, "R9");
    cyc(0, 15'h0, 8'h0, 0, 1, "R4");
    cyc(1, 15'h0102, 8'h11, 0, 0, "R4");
    cyc(1, 15'h0102, 8'h11, 0, 0, "R8");
    cyc(0, 15'h0, 8'h0, 0, 1, "R8");

    // progDone while protected / partial key ignored
    cyc(0, 15'h0, 8'h0, 0, 1, "R9");
    cyc(1, 15'h5555, 8'hAA, 0, 0, "R2");
    cyc(0, 15'h0, 8'h0, 0, 1, "R9");
    cyc(1, 15'h2AAA, 8'h55, 0, 0, "R9");
    // wrong byte at step three
    cyc(1, 15'h5555, 8'hA1, 0, 0, "R6");
    cyc(0, 15'h0, 8'h0, 0, 1, "R8");
    // wrong byte that is step one
    cyc(1, 15'h5555, 8'hAA, 0, 0, "R6");
    cyc(1, 15'h5555, 8'hAA, 0, 0, "R6");
    cyc(1, 15'h2AAA, 8'h55, 0, 0, "R6");
    cyc(1, 15'h5555, 8'hA0, 0, 0, "R6");
    // timeout while armed
    cyc(0, 15'h0, 8'h0, 1, 0, "R7");
    cyc(1, 15'h0200, 8'h77, 0, 0, "R7");
    cyc(0, 15'h0, 8'h0, 0, 1, "R8");
    // timeout after step one, then strobe coinciding with timeout
    cyc(1, 15'h5555, 8'hAA, 0, 0, "R7");
    cyc(0, 15'h0, 8'h0, 1, 0, "R7");
    cyc(1, 15'h2AAA, 8'h55, 0, 0, "R7");
    cyc(0, 15'h0, 8'h0, 0, 1, "R8");
    cyc(1, 15'h5555, 8'hAA, 0, 0, "R7");
    cyc(1, 15'h2AAA, 8'h55, 1, 0, "R7");
    cyc(1, 15'h5555, 8'hA0, 1, 0, "R7");
    cyc(1, 15'h0300, 8'h01, 1, 0, "R7");
    cyc(0, 15'h0, 8'h0, 0, 1, "R4");
    // unkeyed write while protected
    cyc(1, 15'h2AAA, 8'h55, 0, 0, "R5");
    cyc(1, 15'h5555, 8'hAA, 0, 0, "R8");
    cyc(0, 15'h0, 8'h0, 0, 1, "R8");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int pick;
      bit s, to, pd;
      logic [14:0] a;
      logic [7:0] d;
      pick = int'($urandom_range(0, 9));
      s = ($urandom_range(0, 3) != 0);
      to = ($urandom_range(0, 15) == 0);
      pd = ($urandom_range(0, 11) == 0);
      case (pick)
        0, 1, 2: begin a = 15'h5555; d = 8'hAA; end
        3, 4:    begin a = 15'h2AAA; d = 8'h55; end
        5, 6:    begin a = 15'h5555; d = 8'hA0; end
        7:       begin a = 15'h2AAA; d = 8'hAA; end
        default: begin a = 15'($urandom); d = 8'($urandom); end
      endcase
      wrStb = s; wrAddr = a; wrData = d; loadTimeout = to; progDone = pd;
      @(posedge clk);
      modelStep(s, a, d, to, pd);
      @(negedge clk);
      wrStb = 0; loadTimeout = 0; progDone = 0;
      check(tagOf());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule